// File: doc/BRIEF.md
# Parallel Scrambling NRZI Line Encoder

This block takes one luma word and one chroma word per word clock and turns them into one 20-bit slice of an encoded serial line stream. An external 20:1 serializer then sends the slice out least significant bit first. The two words are first combined into one 20-bit serial-order vector. That vector goes through a self-synchronising scrambler with the polynomial x^9 + x^4 + 1, and then through a transition (NRZI, x + 1) stage. All twenty bits are evaluated in a single clock.

Every word is encoded exactly as presented. This holds for picture samples, timing reference codes, line numbers, CRC words and ancillary payload alike: no value is substituted or filtered. The state of the scrambler and of the transition stage carries from one word to the next, and only the synchronous reset clears it. A parameter selects how the two words are combined. In word interleave, the chroma word comes first and the luma word follows. In bit interleave, chroma and luma bits alternate.

Top module: `svenc_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_vld` = 0 and `out_word` = 0, and both the scrambler history and the transition level become 0.
- R2: `out_vld` is high in the cycle after a rising edge where `in_vld` was high, and low in the cycle after one where `in_vld` was low.
- R3: Serial order is `out_word` bit 0 first. With `ILV` = ILV_WORD, serial bit k is `chroma_in[k]` for k < 10 and `luma_in[k-10]` for k >= 10. With `ILV` = ILV_BIT, serial bit 2k is `chroma_in[k]` and serial bit 2k+1 is `luma_in[k]`.
- R4: The scrambled bit is s[n] = d[n] ^ s[n-4] ^ s[n-9] over the serial order. The history carries across consecutive words.
- R5: The line bit is t[n] = s[n] ^ t[n-1], and the level carries across words. After a valid word, the transition stage holds `out_word[19]`.
- R6: A cycle with `in_vld` low leaves `out_word`, the scrambler history and the transition level unchanged.
- R7: Words are encoded without alteration. The values 0x3FF and 0x000 and any other code decode back bit-exactly. All-zero input from the zero state yields an all-zero `out_word`.
- R8: A decoder that starts from arbitrary state recovers the data exactly from serial bit 10 of the stream onward.
- R9: A reset in the middle of a stream restarts the encoding as if from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | A luma/chroma word pair is present this cycle |
| luma_in | input | WORD_W | Luma word |
| chroma_in | input | WORD_W | Chroma word |
| out_vld | output | 1 | `out_word` carries a newly encoded slice |
| out_word | output | 2*WORD_W | Encoded line bits, bit 0 transmitted first |

## Verification
Each encoded slice is registered once, so the result of a word is due exactly one rising edge after the edge that accepted it. That applies to `out_word`, `out_vld` and the updated scrambler and transition state alike. The same single-edge latency governs an idle cycle and a reset cycle: an idle cycle shows its held value one edge later, and the cleared state appears one edge after `rst` is sampled. The bench drives inputs on the falling edge and samples on the next falling edge, halfway between the capture edge and the edge after it. There it compares against a bit-serial model stepped once per accepted word, and it runs a model decoder over the same sampled slice.

// File: rtl/svenc_pkg.sv
package svenc_pkg;
  // scrambler taps of x^9 + x^4 + 1
  localparam int SCR_TAP_NEAR = 4;
  localparam int SCR_TAP_FAR  = 9;

  typedef enum logic {
    ILV_WORD = 1'b0,  // chroma word then luma word
    ILV_BIT  = 1'b1   // chroma/luma bits alternate
  } ilv_mode_e;
endpackage

// File: rtl/svenc_lane_mux.sv
module svenc_lane_mux #(
  parameter int WORD_W = 10,
  parameter svenc_pkg::ilv_mode_e ILV = svenc_pkg::ILV_WORD,
  localparam int BITS = 2 * WORD_W
) (
  input  logic [WORD_W-1:0] luma,
  input  logic [WORD_W-1:0] chroma,
  output logic [BITS-1:0]   ser
);
  generate
    if (ILV == svenc_pkg::ILV_WORD) begin : g_word
      assign ser = {luma, chroma};
    end else begin : g_bit
      for (genvar k = 0; k < WORD_W; k++) begin : g_pair
        assign ser[2*k]   = chroma[k];
        assign ser[2*k+1] = luma[k];
      end
    end
  endgenerate
endmodule

// File: rtl/svenc_scrambler.sv
module svenc_scrambler #(
  parameter int BITS = 20,
  parameter int NEAR = svenc_pkg::SCR_TAP_NEAR,
  parameter int FAR  = svenc_pkg::SCR_TAP_FAR,
  localparam int EXT = FAR + BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] s,
  output logic [FAR-1:0]  state_q
);
  logic [FAR-1:0] state_d;

  // ext[FAR-1] is the most recent history bit, ext[FAR+i] is serial bit i
  always_comb begin
    logic [EXT-1:0] ext;
    ext = '0;
    ext[FAR-1:0] = state_q;
    for (int i = 0; i < BITS; i++) begin
      ext[FAR+i] = d[i] ^ ext[FAR+i-NEAR] ^ ext[i];
    end
    s       = ext[EXT-1:FAR];
    state_d = ext[EXT-1:BITS];
  end

  always_ff @(posedge clk) begin
    if (rst)      state_q <= '0;
    else if (adv) state_q <= state_d;
  end
endmodule

// File: rtl/svenc_nrzi.sv
module svenc_nrzi #(
  parameter int BITS = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [BITS-1:0] s,
  output logic [BITS-1:0] t,
  output logic            last_q
);
  always_comb begin
    logic lvl;
    lvl = last_q;
    for (int i = 0; i < BITS; i++) begin
      lvl  = lvl ^ s[i];
      t[i] = lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      last_q <= 1'b0;
    else if (adv) last_q <= t[BITS-1];
  end
endmodule

// File: rtl/svenc_top.sv
module svenc_top #(
  parameter int WORD_W = 10,
  parameter svenc_pkg::ilv_mode_e ILV = svenc_pkg::ILV_WORD,
  localparam int BITS = 2 * WORD_W,
  localparam int SW   = svenc_pkg::SCR_TAP_FAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] luma_in,
  input  logic [WORD_W-1:0] chroma_in,
  output logic              out_vld,
  output logic [BITS-1:0]   out_word
);
  logic [BITS-1:0] ser_d;
  logic [BITS-1:0] scr_bits;
  logic [BITS-1:0] line_bits;
  logic [SW-1:0]   scr_state_q;
  logic            nrzi_last_q;

  svenc_lane_mux #(.WORD_W(WORD_W), .ILV(ILV)) u_mux (
    .luma(luma_in), .chroma(chroma_in), .ser(ser_d)
  );

  svenc_scrambler #(.BITS(BITS)) u_scr (
    .clk(clk), .rst(rst), .adv(in_vld), .d(ser_d),
    .s(scr_bits), .state_q(scr_state_q)
  );

  svenc_nrzi #(.BITS(BITS)) u_nrzi (
    .clk(clk), .rst(rst), .adv(in_vld), .s(scr_bits),
    .t(line_bits), .last_q(nrzi_last_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_word <= line_bits;
    end
  end
endmodule

// File: rtl/svenc_chk.sv
module svenc_chk #(
  parameter int BITS = 20,
  parameter int WORD_W = 10,
  parameter int SW = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [WORD_W-1:0] luma_in,
  input logic [WORD_W-1:0] chroma_in,
  input logic              out_vld,
  input logic [BITS-1:0]   out_word,
  input logic [SW-1:0]     scr_state,
  input logic              nrzi_last
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  always_ff @(negedge clk) begin
    if (rst_seen) begin
      reset_clear_chk: assert (out_vld == 1'b0 && out_word == '0 && scr_state == '0 && nrzi_last == 1'b0)
        else $error("reset did not clear encoder");
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_word) && $stable(scr_state) && $stable(nrzi_last)));
  // R5
  level_carry_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (nrzi_last == out_word[BITS-1]));
  // R7
  zero_stays_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && luma_in == '0 && chroma_in == '0 && scr_state == '0 && !nrzi_last) |=> (out_word == '0));
endmodule

bind svenc_top svenc_chk #(.BITS(BITS), .WORD_W(WORD_W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .luma_in(luma_in), .chroma_in(chroma_in),
  .out_vld(out_vld), .out_word(out_word), .scr_state(scr_state_q), .nrzi_last(nrzi_last_q)
);

// File: tb/sim_svenc_top.sv
module sim_svenc_top;
  localparam int W = 10;
  localparam int B = 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [W-1:0] luma = '0;
  logic [W-1:0] chroma = '0;
  logic         o_vld0, o_vld1;
  logic [B-1:0] o_word0, o_word1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // bench models: index 0 = word interleave, 1 = bit interleave
  logic [8:0]   m_hist [2];
  logic         m_t    [2];
  logic [B-1:0] m_prev [2];
  logic [8:0]   d_hist [2];
  logic         d_t    [2];
  bit           d_skip [2];

  always #2.5 clk = ~clk;

  svenc_top #(.WORD_W(W), .ILV(svenc_pkg::ILV_WORD)) u0 (
    .clk(clk), .rst(rst), .in_vld(vld), .luma_in(luma), .chroma_in(chroma),
    .out_vld(o_vld0), .out_word(o_word0)
  );
  svenc_top #(.WORD_W(W), .ILV(svenc_pkg::ILV_BIT)) u1 (
    .clk(clk), .rst(rst), .in_vld(vld), .luma_in(luma), .chroma_in(chroma),
    .out_vld(o_vld1), .out_word(o_word1)
  );

  function automatic logic [B-1:0] pack(int k, logic [W-1:0] l, logic [W-1:0] c);
    logic [B-1:0] v;
    for (int i = 0; i < W; i++) begin
      if (k == 0) begin v[i] = c[i]; v[W+i] = l[i]; end
      else begin v[2*i] = c[i]; v[2*i+1] = l[i]; end
    end
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_hist[k] = '0; m_t[k] = 1'b0; m_prev[k] = '0;
      d_hist[k] = '0; d_t[k] = 1'b0; d_skip[k] = 1'b0;
    end
  endtask

  task automatic encode(int k, logic [B-1:0] d, output logic [B-1:0] t);
    for (int i = 0; i < B; i++) begin
      logic s;
      s = d[i] ^ m_hist[k][3] ^ m_hist[k][8];
      m_hist[k] = {m_hist[k][7:0], s};
      m_t[k] = m_t[k] ^ s;
      t[i] = m_t[k];
    end
  endtask

  task automatic decode(int k, logic [B-1:0] t, output logic [B-1:0] d);
    for (int i = 0; i < B; i++) begin
      logic s;
      s = t[i] ^ d_t[k];
      d_t[k] = t[i];
      d[i] = s ^ d_hist[k][3] ^ d_hist[k][8];
      d_hist[k] = {d_hist[k][7:0], s};
    end
  endtask

  task automatic chk(string req, logic [B-1:0] act, logic [B-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic step(bit v, logic [W-1:0] l, logic [W-1:0] c, string req);
    vld = v; luma = l; chroma = c;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      logic [B-1:0] act, exp, dec;
      act = (k == 0) ? o_word0 : o_word1;
      chk({req, " R2 out_vld"}, {19'd0, (k == 0) ? o_vld0 : o_vld1}, {19'd0, v});
      if (v) begin
        encode(k, pack(k, l, c), exp);
        m_prev[k] = exp;
        chk({req, " R3 R4 R5 encode"}, act, exp);
        decode(k, act, dec);
        if (d_skip[k]) begin
          chk({req, " R8 upper half"}, {10'd0, dec[B-1:10]}, {10'd0, pack(k, l, c) >> 10});
          d_skip[k] = 1'b0;
        end else begin
          chk({req, " R7 round trip"}, dec, pack(k, l, c));
        end
      end else begin
        chk({req, " R6 hold"}, act, m_prev[k]);
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; vld = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 reset word", o_word0, '0);
    chk("R1 reset word", o_word1, '0);
    chk("R1 reset vld", {19'd0, o_vld0 | o_vld1}, '0);
  endtask

  task automatic t_zero();
    for (int n = 0; n < 4; n++) step(1'b1, '0, '0, "R7 zero");
    chk("R7 zero output", o_word0 | o_word1, '0);
  endtask

  task automatic t_single();
    step(1'b1, 10'h000, 10'h001, "R4 impulse");
    for (int n = 0; n < 3; n++) step(1'b1, '0, '0, "R4 impulse tail");
  endtask

  task automatic t_timing();
    step(1'b1, 10'h3FF, 10'h3FF, "R7 trs");
    step(1'b1, 10'h000, 10'h000, "R7 trs");
    step(1'b1, 10'h000, 10'h000, "R7 trs");
    step(1'b1, 10'h274, 10'h274, "R7 trs");
  endtask

  task automatic t_walk();
    for (int i = 0; i < W; i++) step(1'b1, 10'(1 << i), 10'(1 << (W - 1 - i)), "R3 walk");
  endtask

  task automatic t_idle();
    step(1'b1, 10'h155, 10'h2AA, "R6 pre");
    step(1'b0, 10'h3FF, 10'h3FF, "R6 idle");
    step(1'b0, 10'h123, 10'h321, "R6 idle");
    step(1'b1, 10'h0F0, 10'h00F, "R6 resume");
  endtask

  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      bit v;
      v = ($urandom % 5) != 0;
      step(v, 10'($urandom), 10'($urandom), "R4 R5 random");
    end
  endtask

  task automatic t_resync();
    for (int k = 0; k < 2; k++) begin
      d_hist[k] = 9'h1A5; d_t[k] = 1'b1; d_skip[k] = 1'b1;
    end
    step(1'b1, 10'h2C3, 10'h1B7, "R8 first");
    step(1'b1, 10'h0A5, 10'h35A, "R8 second");
  endtask

  task automatic t_midreset();
    step(1'b1, 10'h3A1, 10'h05C, "R9 pre");
    t_reset();
    step(1'b1, 10'h000, 10'h001, "R9 restart");
    step(1'b1, 10'h3FF, 10'h000, "R9 restart");
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    t_reset();
    t_zero();
    t_single();
    t_timing();
    t_walk();
    t_idle();
    t_random();
    t_resync();
    t_midreset();
    step(1'b0, '0, '0, "R6 end");
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule